// File: doc/BRIEF.md
# Message-controller interrupt identifier arbiter

This block merges the interrupt causes of a message controller into one identifier register and one active-low request line to the processor. A controller-status cause outranks every message cause. When the protocol engine writes its status register, the block raises a sticky status interrupt. An error-class write counts only when the error enable is set, and a status-class write counts only when the status enable is set. The sticky flag drops when the processor reads the status register. While that flag is set, the identifier shows the fixed code 0x8000.

Below the status cause, each message object has a pending flag. The objects are numbered from 1, and the lowest-numbered pending object wins. When software clears that object's pending flag, the identifier moves on to the next pending object. The identifier always follows its causes, whatever the state of the line enable. The line enable only decides whether a nonzero identifier drives the request line low.

Top module: `can_intid_arb`

## Requirements
- R1: When neither the status flag nor any message pending flag is set, the identifier reads 0x0000.
- R2: While the status flag is set, the identifier reads 0x8000, regardless of the message pending flags.
- R3: With no status flag, the identifier equals k, where obj_pend bit k-1 is the lowest set bit (object k, from 1 to NUM_OBJ).
- R4: A core_err_upd pulse sets the status flag only when ctl_eie is 1. A core_sts_upd pulse sets it only when ctl_sie is 1. Each qualifying pulse sets the flag, even if the flag is already set.
- R5: A cpu_sts_rd strobe without cpu_sts_wr clears the status flag.
- R6: A cpu_sts_wr strobe never sets or clears the status flag. If cpu_sts_rd and cpu_sts_wr are both high in a cycle, the access counts as a write and the flag is left unchanged.
- R7: Clearing the pending bit of the reported object moves the identifier to the next lowest-numbered pending object, or to 0 if none is left.
- R8: irq_n is 0 exactly when ctl_ie is 1 and the identifier is nonzero. Otherwise it is 1.
- R9: The identifier keeps tracking its causes while ctl_ie is 0.
- R10: If a qualifying core update and a status read happen in the same cycle, the status flag is set.
- R11: The identifier and the status flag are registered and reflect their inputs one clock later. A synchronous active-high rst clears both, so the identifier is 0 and irq_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| obj_pend | input | NUM_OBJ | Message pending flags, bit k-1 = object k |
| core_err_upd | input | 1 | Core wrote status register, error class |
| core_sts_upd | input | 1 | Core wrote status register, status class |
| cpu_sts_rd | input | 1 | Processor read of status register |
| cpu_sts_wr | input | 1 | Processor write of status register |
| ctl_ie | input | 1 | Request line enable |
| ctl_eie | input | 1 | Error-update interrupt enable |
| ctl_sie | input | 1 | Status-update interrupt enable |
| int_id | output | ID_W | Interrupt identifier |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
On every cycle, the assertions check the following:
- the status code appears one clock after a qualifying update;
- the flag stays set without a pure read;
- a read-only strobe with no new update removes the status code;
- message identifiers stay within range;
- the request line agrees with the enable and the identifier.

Only the bench scenarios show certain behaviours:
- that the lowest pending object wins across varied patterns;
- that disabled update classes are ignored;
- the walk down the pending objects as each one is cleared;
- that the identifier keeps tracking with the line disabled.

The bench shows these by comparing against its own model every clock.

// File: rtl/can_intid_arb.sv
module can_intid_arb #(
  parameter int NUM_OBJ = 32,
  parameter int ID_W    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OBJ-1:0] obj_pend,
  input  logic               core_err_upd,
  input  logic               core_sts_upd,
  input  logic               cpu_sts_rd,
  input  logic               cpu_sts_wr,
  input  logic               ctl_ie,
  input  logic               ctl_eie,
  input  logic               ctl_sie,
  output logic [ID_W-1:0]    int_id,
  output logic               irq_n
);
  localparam logic [ID_W-1:0] STS_CODE = ID_W'(1) << (ID_W - 1);

  logic            sts_q, sts_d;
  logic [ID_W-1:0] msg_id;

  wire sts_set = (core_err_upd & ctl_eie) | (core_sts_upd & ctl_sie);
  wire sts_clr = cpu_sts_rd & ~cpu_sts_wr;

  assign sts_d = sts_set | (sts_q & ~sts_clr);

  always_comb begin
    msg_id = '0;
    for (int k = NUM_OBJ - 1; k >= 0; k--)
      if (obj_pend[k]) msg_id = ID_W'(k + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q  <= 1'b0;
      int_id <= '0;
    end else begin
      sts_q  <= sts_d;
      int_id <= sts_d ? STS_CODE : msg_id;
    end
  end

  assign irq_n = ~(ctl_ie & (int_id != '0));
endmodule

module can_intid_arb_chk #(
  parameter int NUM_OBJ = 32,
  parameter int ID_W    = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_OBJ-1:0] obj_pend,
  input logic               core_err_upd,
  input logic               core_sts_upd,
  input logic               cpu_sts_rd,
  input logic               cpu_sts_wr,
  input logic               ctl_ie,
  input logic               ctl_eie,
  input logic               ctl_sie,
  input logic [ID_W-1:0]    int_id,
  input logic               irq_n
);
  localparam logic [ID_W-1:0] CODE = ID_W'(1) << (ID_W - 1);
  wire upd = (core_err_upd & ctl_eie) | (core_sts_upd & ctl_sie);

  assert_status_code_R2: assert property (@(posedge clk) disable iff (rst)
    upd |=> int_id == CODE);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (int_id == CODE && !(cpu_sts_rd && !cpu_sts_wr)) |=> int_id == CODE);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (cpu_sts_rd && !cpu_sts_wr && !upd) |=> int_id != CODE);

  assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (rst)
    (!upd && int_id != CODE) |=> int_id != CODE);

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (!upd && obj_pend == '0 && (int_id != CODE || (cpu_sts_rd && !cpu_sts_wr)))
      |=> int_id == '0);

  assert_id_range_R3: assert property (@(posedge clk) disable iff (rst)
    (int_id != CODE) |-> int_id <= ID_W'(NUM_OBJ));

  assert_line_R8: assert property (@(posedge clk) disable iff (rst)
    (!ctl_ie || int_id == '0) |-> irq_n);
endmodule

bind can_intid_arb can_intid_arb_chk #(.NUM_OBJ(NUM_OBJ), .ID_W(ID_W)) u_chk (.*);

// File: tb/test_can_intid_arb.sv
`timescale 1ns/1ps
module test_can_intid_arb;
  localparam int N = 32;
  logic clk = 0, rst = 1;
  logic [N-1:0] obj_pend = '0;
  logic core_err_upd = 0, core_sts_upd = 0, cpu_sts_rd = 0, cpu_sts_wr = 0;
  logic ctl_ie = 0, ctl_eie = 0, ctl_sie = 0;
  logic [15:0] int_id;
  logic irq_n;
  int checks = 0, failures = 0;
  int m_sts = 0, m_id = 0;
  bit done = 0;

  can_intid_arb i_can_intid_arb (.*);

  always #2 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin m_sts = 0; m_id = 0; end
    else begin
      if ((core_err_upd && ctl_eie) || (core_sts_upd && ctl_sie)) m_sts = 1;
      else if (cpu_sts_rd && !cpu_sts_wr) m_sts = 0;
      m_id = 0;
      if (m_sts) m_id = 32768;
      else for (int k = 0; k < N; k++) if (obj_pend[k] && m_id == 0) m_id = k + 1;
    end
  end

  always @(negedge clk) if (!rst && !done) begin
    chk(m_id == 0 ? "R1" : (m_id == 32768 ? "R2" : "R3"), int_id, m_id);
    chk("R8", irq_n, !(ctl_ie && m_id != 0));
  end

  task automatic tick();
    @(posedge clk); #1;
    core_err_upd = 0; core_sts_upd = 0; cpu_sts_rd = 0; cpu_sts_wr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset id", int_id, 0);
    chk("R11 reset irq", irq_n, 1);
    rst = 0; ctl_ie = 1;
    tick();
    chk("R1 idle", int_id, 0);
    // R3: bit k-1 gives id k
    obj_pend = 32'h0000_0010; tick(); chk("R3 single", int_id, 5);
    chk("R8 line low", irq_n, 0);
    obj_pend = 32'h8000_0000; tick(); chk("R3 top", int_id, 32);
    obj_pend = 32'h8010_0104; tick(); chk("R3 lowest", int_id, 3);
    // R7 walk
    obj_pend = 32'h8010_0100; tick(); chk("R7 next", int_id, 9);
    obj_pend = 32'h8010_0000; tick(); chk("R7 next", int_id, 21);
    obj_pend = 32'h8000_0000; tick(); chk("R7 next", int_id, 32);
    obj_pend = 0; tick(); chk("R7 empty", int_id, 0);
    chk("R8 line high", irq_n, 1);
    // R4 gating
    core_err_upd = 1; tick(); chk("R4 eie off", int_id, 0);
    core_sts_upd = 1; tick(); chk("R4 sie off", int_id, 0);
    ctl_eie = 1; obj_pend = 32'h1;
    core_err_upd = 1; tick(); chk("R4 err on", int_id, 16'h8000);
    chk("R2 beats obj1", int_id, 16'h8000);
    // R6 write cannot clear
    cpu_sts_wr = 1; tick(); chk("R6 wr no clear", int_id, 16'h8000);
    cpu_sts_wr = 1; cpu_sts_rd = 1; tick(); chk("R6 rd+wr", int_id, 16'h8000);
    // R5 read clears
    cpu_sts_rd = 1; tick(); chk("R5 read clear", int_id, 1);
    cpu_sts_wr = 1; tick(); chk("R6 wr no set", int_id, 1);
    // R4 sie path, repeat update while set
    ctl_sie = 1; ctl_eie = 0;
    core_sts_upd = 1; tick(); chk("R4 sts on", int_id, 16'h8000);
    core_sts_upd = 1; tick(); chk("R4 repeat", int_id, 16'h8000);
    // R10 update and read together
    core_sts_upd = 1; cpu_sts_rd = 1; tick(); chk("R10 update wins", int_id, 16'h8000);
    cpu_sts_rd = 1; tick(); chk("R5 read clear", int_id, 1);
    // R9 tracking with IE off
    ctl_ie = 0; obj_pend = 32'h0000_0600; tick();
    chk("R9 track", int_id, 10); chk("R8 ie off", irq_n, 1);
    core_sts_upd = 1; tick(); chk("R9 status", int_id, 16'h8000);
    ctl_ie = 1; #0.5; chk("R8 ie on", irq_n, 0);
    // R11 latency: change visible only after edge
    cpu_sts_rd = 1; obj_pend = 32'h0000_0002;
    @(negedge clk); chk("R11 latency", int_id, 16'h8000);
    @(posedge clk); #1; cpu_sts_rd = 0;
    chk("R11 next", int_id, 2);
    // random phase
    for (int i = 0; i < 400; i++) begin
      obj_pend = $urandom; if (i % 3 == 0) obj_pend = 0;
      core_err_upd = ($urandom % 6) == 0; core_sts_upd = ($urandom % 6) == 0;
      cpu_sts_rd = ($urandom % 3) == 0; cpu_sts_wr = ($urandom % 4) == 0;
      ctl_ie = $urandom; ctl_eie = $urandom; ctl_sie = $urandom;
      @(posedge clk); #1;
    end
    rst = 1; tick(); chk("R11 reset again", int_id, 0);
    chk("R11 reset irq", irq_n, 1);
    finish_run();
  end
endmodule